// File: doc/BRIEF.md
# Reconfigurable Convolution Element Row with Mode-Routed Partial Sums

This block is one row of a convolution engine: twelve multiply-accumulate elements in a fixed chain. Eight are plain multiply-add elements. Four are special elements that can also clamp negative results to zero. A kernel-mode input is decoded into seven routing selects. These selects decide where each partial-sum chain starts and ends, so the same row serves 3x3, 5x5 and 11x11 kernels. Each cycle, every element takes one pixel and one weight. The block skews those operands internally so that every subset adds up products of the same input sample. Finished subset sums leave on up to four result lanes, each with its own valid flag.

The chain order is fixed. Elements E0..E11 are plain, plain, special, repeated four times. The special elements sit at E2, E5, E8 and E11. Every element registers its output once per cycle.

For verification there is a select-override port. It inverts one chosen select bit, so that a test can show the exact wrong routing that a flipped select produces. The port is inert unless it is enabled.

Top module: `pe_row_router`

## Requirements
- R1: While reset is held and right after it is released, every bit of `res_valid_o` is 0 and every result lane reads 0.
- R2: Mode 2'b00 (3x3) gives four subsets of three elements. Lane L carries the sum of pixel*weight over elements E(3L)..E(3L+2) of one sample. Lane L is valid 3*(L+1) rising edges after the edge that captured the sample, counting that edge as 1. In this mode the selects are m1=0, m2=1, m3=0, m4=01, m5=0, m6=1, m7=00.
- R3: Mode 2'b01 (5x5) gives two subsets of six elements. Lane 0 carries the sum over E0..E5 and is valid after 6 edges. Lane 1 carries the sum over E6..E11 and is valid after 12 edges. Lanes 2 and 3 are never valid.
- R4: Mode 2'b10 (11x11) gives one subset of all twelve elements. Lane 0 carries it and is valid after 12 edges. Lanes 1 to 3 are never valid.
- R5: When `act_en_i` is 1, a special element that ends a subset outputs max(0, sum). A special element inside a longer chain passes its sum on unclamped. When `act_en_i` is 0, all results are raw signed sums.
- R6: Samples presented on consecutive cycles give results on consecutive cycles on each lane, in order, with no loss.
- R7: In 3x3 mode, inverting m1 (override index 0) routes E2's output into E3. Lane 1 then carries the sum over E0..E5, and lane 0 is unchanged.
- R8: In 3x3 mode, inverting m3 (override index 2) cuts E3 and E4 off from E5. Lane 1 then carries only E5's product.
- R9: With `ovr_en_i` = 0, the value of `ovr_idx_i` has no effect on any result.
- R10: The reserved mode code 2'b11 behaves exactly as 3x3 mode.
- R11: Override index map: 0=m1, 1=m2, 2=m3, 3=m4 bit0, 4=m4 bit1, 5=m5, 6=m6, 7=m7 bit0, 8=m7 bit1. Indices 9 to 15 flip nothing. At most one select bit differs from the mode's select word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Kernel mode: 00 3x3, 01 5x5, 10 11x11, 11 reserved (as 3x3) |
| act_en_i | input | 1 | Enables zero-clamping at subset-ending special elements |
| in_valid_i | input | 1 | Marks the pixel and weight vectors as a sample |
| pix_i | input | 12*PIX_W | Signed pixel for element i in bits [i*PIX_W +: PIX_W] |
| wgt_i | input | 12*WGT_W | Signed weight for element i in bits [i*WGT_W +: WGT_W] |
| ovr_en_i | input | 1 | Enables the verification select override |
| ovr_idx_i | input | 4 | Select bit to invert, per the R11 index map |
| res_o | output | 4*SUM_W | Signed result lane L in bits [L*SUM_W +: SUM_W], 0 when not valid |
| res_valid_o | output | 4 | Per-lane valid flag |

## Verification
The bench checks each lane's value and the exact cycle it turns valid. A design with wrong operand skew would add products from different samples, and a design with an off-by-one latency would flag its results one edge early or late. Activation is tested with weights chosen to make some subsets negative, including a 5x5 case where an interior special element carries a negative partial sum; a design that clamped inside a chain would report a positive total there. The override tests flip m1 and m3 and expect the specific merged and truncated sums described in the requirements. A disabled override and the reserved mode must leave the 3x3 results untouched.

// File: rtl/pe_route_pkg.sv
package pe_route_pkg;

    localparam int NUM_EL   = 12;
    localparam int NUM_LANE = 4;
    localparam int SEL_BITS = 9;

    typedef struct packed {
        logic [1:0] m7;   // lane packing: 00 natural, 01 two lanes, 10 single lane
        logic       m6;   // E8 chain input: 1 from E7, 0 from zero
        logic       m5;   // E9 chain input: 1 from E8, 0 from zero
        logic [1:0] m4;   // E6 chain input: 00 from E5, others zero
        logic       m3;   // E5 chain input: 0 from E4, 1 from zero
        logic       m2;   // E2 chain input: 1 from E1, 0 from zero
        logic       m1;   // E3 chain input: 1 from E2, 0 from zero
    } route_sel_t;

    localparam route_sel_t SEL_K3  = '{m7: 2'b00, m6: 1'b1, m5: 1'b0, m4: 2'b01,
                                       m3: 1'b0, m2: 1'b1, m1: 1'b0};
    localparam route_sel_t SEL_K5  = '{m7: 2'b01, m6: 1'b1, m5: 1'b1, m4: 2'b01,
                                       m3: 1'b0, m2: 1'b1, m1: 1'b1};
    localparam route_sel_t SEL_K11 = '{m7: 2'b10, m6: 1'b1, m5: 1'b1, m4: 2'b00,
                                       m3: 1'b0, m2: 1'b1, m1: 1'b1};

    function automatic route_sel_t sel_for_mode(input logic [1:0] mode);
        case (mode)
            2'b01:   return SEL_K5;
            2'b10:   return SEL_K11;
            default: return SEL_K3;
        endcase
    endfunction

endpackage

// File: rtl/pe_route_ctrl.sv
module pe_route_ctrl
    import pe_route_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       ovr_en_i,
    input  logic [3:0] ovr_idx_i,
    output route_sel_t sel_o
);

    route_sel_t base_sel;
    logic [SEL_BITS-1:0] flip_mask;

    always_comb begin
        base_sel  = sel_for_mode(mode_i);
        flip_mask = '0;
        if (ovr_en_i && (int'(ovr_idx_i) < SEL_BITS)) begin
            flip_mask[ovr_idx_i] = 1'b1;
        end
        sel_o = route_sel_t'(base_sel ^ flip_mask);
    end

    // R11: the override never disturbs more than one select bit
    p_single_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_o ^ sel_for_mode(mode_i)) <= 1);

    // R10: reserved code drives the 3x3 select word
    p_reserved_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11 && !ovr_en_i) |-> (sel_o == SEL_K3));

endmodule

// File: rtl/pe_skew.sv
module pe_skew #(
    parameter int W     = 16,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    typedef logic [W-1:0] stage_t;

    stage_t sh_d [DEPTH];
    stage_t sh_q [DEPTH];

    always_comb begin
        sh_d[0] = in_i;
        for (int i = 1; i < DEPTH; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sh_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) sh_q[i] <= sh_d[i];
        end
    end

    assign out_o = sh_q[DEPTH-1];

endmodule

// File: rtl/pe_cell.sv
module pe_cell #(
    parameter int PIX_W      = 8,
    parameter int WGT_W      = 8,
    parameter int SUM_W      = 24,
    parameter bit IS_SPECIAL = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [PIX_W-1:0] pix_i,
    input  logic signed [WGT_W-1:0] wgt_i,
    input  logic signed [SUM_W-1:0] psum_i,
    input  logic                    act_i,
    output logic signed [SUM_W-1:0] sum_o
);

    localparam int PROD_W = PIX_W + WGT_W;

    typedef struct packed {
        logic signed [SUM_W-1:0] sum;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  total;
    logic                     act_eff;

    always_comb begin
        prod    = pix_i * wgt_i;
        total   = psum_i + SUM_W'(prod);
        act_eff = IS_SPECIAL && act_i;
        st_d.sum = (act_eff && total < 0) ? '0 : total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_o = st_q.sum;

    if (IS_SPECIAL) begin : g_chk
        // R5: a clamping element never leaves a negative value behind
        p_clamp_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
            act_i |=> !sum_o[SUM_W-1]);
    end

endmodule

// File: rtl/pe_row_router.sv
module pe_row_router
    import pe_route_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int WGT_W = 8,
    parameter int SUM_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 mode_i,
    input  logic                       act_en_i,
    input  logic                       in_valid_i,
    input  logic [NUM_EL*PIX_W-1:0]    pix_i,
    input  logic [NUM_EL*WGT_W-1:0]    wgt_i,
    input  logic                       ovr_en_i,
    input  logic [3:0]                 ovr_idx_i,
    output logic [NUM_LANE*SUM_W-1:0]  res_o,
    output logic [NUM_LANE-1:0]        res_valid_o
);

    localparam int OPND_W = PIX_W + WGT_W;

    typedef struct packed {
        logic [NUM_EL-1:0] vld;
    } row_st_t;

    row_st_t    st_d, st_q;
    route_sel_t sel;

    logic signed [SUM_W-1:0] el_in  [NUM_EL];
    logic signed [SUM_W-1:0] el_out [NUM_EL];
    logic [NUM_EL-1:0]       el_act;

    logic [SUM_W-1:0]    lane_val [NUM_LANE];
    logic [NUM_LANE-1:0] lane_vld;

    pe_route_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .ovr_en_i  (ovr_en_i),
        .ovr_idx_i (ovr_idx_i),
        .sel_o     (sel)
    );

    // Chain links and activation points follow the select word
    always_comb begin
        el_in[0]  = '0;
        el_in[1]  = el_out[0];
        el_in[2]  = sel.m2 ? el_out[1] : '0;
        el_in[3]  = sel.m1 ? el_out[2] : '0;
        el_in[4]  = el_out[3];
        el_in[5]  = sel.m3 ? '0 : el_out[4];
        el_in[6]  = (sel.m4 == 2'b00) ? el_out[5] : '0;
        el_in[7]  = el_out[6];
        el_in[8]  = sel.m6 ? el_out[7] : '0;
        el_in[9]  = sel.m5 ? el_out[8] : '0;
        el_in[10] = el_out[9];
        el_in[11] = el_out[10];

        el_act     = '0;
        el_act[2]  = act_en_i && !sel.m1;
        el_act[5]  = act_en_i && (sel.m4 != 2'b00);
        el_act[8]  = act_en_i && !sel.m5;
        el_act[11] = act_en_i;
    end

    for (genvar g = 0; g < NUM_EL; g++) begin : g_el
        logic [OPND_W-1:0] opnd_raw;
        logic [OPND_W-1:0] opnd_al;

        assign opnd_raw = {wgt_i[g*WGT_W +: WGT_W], pix_i[g*PIX_W +: PIX_W]};

        if (g == 0) begin : g_noskew
            assign opnd_al = opnd_raw;
        end else begin : g_skew
            pe_skew #(.W(OPND_W), .DEPTH(g)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .in_i  (opnd_raw),
                .out_o (opnd_al)
            );
        end

        pe_cell #(
            .PIX_W      (PIX_W),
            .WGT_W      (WGT_W),
            .SUM_W      (SUM_W),
            .IS_SPECIAL ((g % 3) == 2)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pix_i  (opnd_al[PIX_W-1:0]),
            .wgt_i  (opnd_al[OPND_W-1:PIX_W]),
            .psum_i (el_in[g]),
            .act_i  (el_act[g]),
            .sum_o  (el_out[g])
        );
    end

    // Valid travels alongside the operand skew
    always_comb begin
        st_d.vld = {st_q.vld[NUM_EL-2:0], in_valid_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Lane packing
    always_comb begin
        for (int l = 0; l < NUM_LANE; l++) begin
            lane_val[l] = '0;
        end
        lane_vld = '0;
        case (sel.m7)
            2'b01: begin
                lane_val[0] = el_out[5];
                lane_vld[0] = st_q.vld[5];
                lane_val[1] = el_out[11];
                lane_vld[1] = st_q.vld[11];
            end
            2'b10: begin
                lane_val[0] = el_out[11];
                lane_vld[0] = st_q.vld[11];
            end
            default: begin
                for (int l = 0; l < NUM_LANE; l++) begin
                    lane_val[l] = el_out[3*l+2];
                    lane_vld[l] = st_q.vld[3*l+2];
                end
            end
        endcase
        for (int l = 0; l < NUM_LANE; l++) begin
            res_o[l*SUM_W +: SUM_W] = lane_vld[l] ? lane_val[l] : '0;
        end
        res_valid_o = lane_vld;
    end

    // R3: two-lane packing never raises the upper lanes
    p_lane_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.m7 == 2'b01) |-> (res_valid_o[3:2] == 2'b00));

    // R4: single-lane packing raises lane 0 at most
    p_lane_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.m7 == 2'b10) |-> (res_valid_o[3:1] == 3'b000));

    // R1: a lane that is not valid presents zero
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o[0] |-> (res_o[SUM_W-1:0] == '0));

endmodule

// File: tb/tb_pe_row_router.sv
`timescale 1ns/1ps
module tb_pe_row_router;

    localparam int PW = 8;
    localparam int WW = 8;
    localparam int SW = 24;
    localparam int NE = 12;
    localparam int NL = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        mode_i;
    logic              act_en_i;
    logic              in_valid_i;
    logic [NE*PW-1:0]  pix_i;
    logic [NE*WW-1:0]  wgt_i;
    logic              ovr_en_i;
    logic [3:0]        ovr_idx_i;
    logic [NL*SW-1:0]  res_o;
    logic [NL-1:0]     res_valid_o;

    int checks = 0;
    int errors = 0;

    longint pv [NE];
    longint wv [NE];

    always #2.5 clk = ~clk;

    pe_row_router #(.PIX_W(PW), .WGT_W(WW), .SUM_W(SW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .act_en_i    (act_en_i),
        .in_valid_i  (in_valid_i),
        .pix_i       (pix_i),
        .wgt_i       (wgt_i),
        .ovr_en_i    (ovr_en_i),
        .ovr_idx_i   (ovr_idx_i),
        .res_o       (res_o),
        .res_valid_o (res_valid_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive_vectors();
        for (int i = 0; i < NE; i++) begin
            pix_i[i*PW +: PW] = PW'(pv[i]);
            wgt_i[i*WW +: WW] = WW'(wv[i]);
        end
    endtask

    task automatic load_seed(input int seed);
        for (int i = 0; i < NE; i++) begin
            pv[i] = longint'((seed * 29 + i * 41 + 7) % 251) - 125;
            wv[i] = longint'((seed * 17 + i * 23 + 3) % 241) - 120;
        end
        drive_vectors();
    endtask

    function automatic longint span(input int a, input int b);
        longint s = 0;
        for (int i = a; i <= b; i++) s += pv[i] * wv[i];
        return s;
    endfunction

    function automatic longint relu(input longint v, input bit on);
        return (on && v < 0) ? 0 : v;
    endfunction

    function automatic longint lane(input int l);
        return longint'($signed(res_o[l*SW +: SW]));
    endfunction

    // One sample; each lane's first valid value and cycle are compared
    task automatic run_sample(input logic [1:0] mode, input bit act,
                              input bit oe, input logic [3:0] oi,
                              input longint ev [NL], input int elat [NL],
                              input string req);
        longint got [NL];
        int     lat [NL];
        for (int l = 0; l < NL; l++) begin
            lat[l] = -1;
            got[l] = 0;
        end
        @(negedge clk);
        mode_i     = mode;
        act_en_i   = act;
        ovr_en_i   = oe;
        ovr_idx_i  = oi;
        drive_vectors();
        in_valid_i = 1'b1;
        for (int c = 1; c <= 16; c++) begin
            @(negedge clk);
            if (c == 1) in_valid_i = 1'b0;
            for (int l = 0; l < NL; l++) begin
                if (res_valid_o[l] && lat[l] < 0) begin
                    lat[l] = c;
                    got[l] = lane(l);
                end
            end
        end
        for (int l = 0; l < NL; l++) begin
            check(lat[l] == elat[l], req, $sformatf("lane %0d latency", l),
                  longint'(lat[l]), longint'(elat[l]));
            if (elat[l] > 0) begin
                check(got[l] == ev[l], req, $sformatf("lane %0d value", l),
                      got[l], ev[l]);
            end
        end
        ovr_en_i = 1'b0;
    endtask

    task automatic t_reset();
        check(res_valid_o == '0, "R1", "valid after reset", longint'(res_valid_o), 0);
        check(res_o == '0, "R1", "lanes after reset", longint'(res_o[SW-1:0]), 0);
    endtask

    task automatic t_k3(input int seed, input bit act, input logic [1:0] code,
                        input string req);
        longint ev [NL];
        int     el [NL];
        load_seed(seed);
        for (int l = 0; l < NL; l++) begin
            ev[l] = relu(span(3*l, 3*l+2), act);
            el[l] = 3 * (l + 1);
        end
        run_sample(code, act, 1'b0, 4'd0, ev, el, req);
    endtask

    task automatic t_k5(input int seed);
        longint ev [NL] = '{0, 0, 0, 0};
        int     el [NL] = '{6, 12, -1, -1};
        load_seed(seed);
        ev[0] = span(0, 5);
        ev[1] = span(6, 11);
        run_sample(2'b01, 1'b0, 1'b0, 4'd0, ev, el, "R3");
    endtask

    task automatic t_k11(input int seed);
        longint ev [NL] = '{0, 0, 0, 0};
        int     el [NL] = '{12, -1, -1, -1};
        load_seed(seed);
        ev[0] = span(0, 11);
        run_sample(2'b10, 1'b0, 1'b0, 4'd0, ev, el, "R4");
    endtask

    // Negative first subset: tests clamping at ends and not inside chains
    task automatic t_relu();
        longint ev [NL];
        int     el3 [NL] = '{3, 6, 9, 12};
        int     el5 [NL] = '{6, 12, -1, -1};
        for (int i = 0; i < NE; i++) begin
            pv[i] = 5;
            wv[i] = (i < 3) ? -3 : 2;
        end
        drive_vectors();
        ev = '{0, 30, 30, 30};
        run_sample(2'b00, 1'b1, 1'b0, 4'd0, ev, el3, "R5");
        ev = '{-45, 30, 30, 30};
        run_sample(2'b00, 1'b0, 1'b0, 4'd0, ev, el3, "R5");
        // 5x5: E2 holds -45 inside the chain; total -15 clamps to 0
        ev = '{0, 60, 0, 0};
        run_sample(2'b01, 1'b1, 1'b0, 4'd0, ev, el5, "R5");
    endtask

    task automatic t_flip(input logic [3:0] idx, input int seed);
        longint ev [NL];
        int     el [NL] = '{3, 6, 9, 12};
        load_seed(seed);
        for (int l = 0; l < NL; l++) ev[l] = span(3*l, 3*l+2);
        if (idx == 4'd0) begin
            ev[1] = span(0, 5);
            run_sample(2'b00, 1'b0, 1'b1, idx, ev, el, "R7");
        end else begin
            ev[1] = span(5, 5);
            run_sample(2'b00, 1'b0, 1'b1, idx, ev, el, "R8");
        end
    endtask

    task automatic t_ovr_off(input int seed);
        longint ev [NL];
        int     el [NL] = '{3, 6, 9, 12};
        load_seed(seed);
        for (int l = 0; l < NL; l++) ev[l] = span(3*l, 3*l+2);
        run_sample(2'b00, 1'b0, 1'b0, 4'd0, ev, el, "R9");
        run_sample(2'b00, 1'b0, 1'b0, 4'd2, ev, el, "R9");
    endtask

    task automatic t_stream();
        longint e0 [3];
        longint e3 [3];
        int     n3 = 0;
        mode_i    = 2'b00;
        act_en_i  = 1'b0;
        ovr_en_i  = 1'b0;
        for (int c = 1; c <= 18; c++) begin
            @(negedge clk);
            if (c <= 3) begin
                load_seed(40 + c);
                e0[c-1]    = span(0, 2);
                e3[c-1]    = span(9, 11);
                in_valid_i = 1'b1;
            end else begin
                in_valid_i = 1'b0;
            end
            // outputs here reflect edges up to (c-1)
            if (c >= 4 && c <= 6) begin
                check(res_valid_o[0] == 1'b1, "R6", "lane 0 valid in stream",
                      longint'(res_valid_o[0]), 1);
                check(lane(0) == e0[c-4], "R6", "lane 0 stream value", lane(0), e0[c-4]);
            end
            if (c >= 13 && c <= 15) begin
                check(lane(3) == e3[c-13], "R6", "lane 3 stream value", lane(3), e3[c-13]);
            end
            if (res_valid_o[3]) n3++;
        end
        check(n3 == 3, "R6", "lane 3 result count", longint'(n3), 3);
    endtask

    initial begin
        rst_n      = 1'b0;
        mode_i     = 2'b00;
        act_en_i   = 1'b0;
        in_valid_i = 1'b0;
        pix_i      = '0;
        wgt_i      = '0;
        ovr_en_i   = 1'b0;
        ovr_idx_i  = 4'd0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_k3(1, 1'b0, 2'b00, "R2");
        t_k3(7, 1'b0, 2'b00, "R2");
        t_k3(3, 1'b1, 2'b00, "R5");
        t_k5(2);
        t_k5(9);
        t_k11(4);
        t_k11(13);
        t_relu();
        t_flip(4'd0, 5);
        t_flip(4'd2, 6);
        t_ovr_off(8);
        t_k3(10, 1'b0, 2'b11, "R10");
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule